// File: doc/BRIEF.md
# Five-Pin GPIO Port with Peripheral Pin Override

This block is a five-pin general-purpose I/O port whose pins can be claimed by three on-chip peripherals. Software controls the port through two registers on a small register bus. The data register holds the values that output pins drive. The direction register marks each pin as an output (1) or an input (0). When a peripheral is enabled, it takes its pins over from the GPIO function. It then sets the value and output enable of each of those pins directly.

The pins have a fixed layout. Bit 4 is SPI MOSI, bit 3 is SPI slave select and bit 2 is SPI MISO. Bit 1 is the transmit pin shared by the CAN controller and the UART. Bit 0 is the receive pin shared by the same two controllers. The pin inputs arrive already synchronized. The block produces per-pin output values and output enables, the register readback, and the receive-side signals routed to each peripheral. All of its outputs follow the inputs and the registers combinationally. Only the two registers hold state.

Top module: `gpio_altfunc_port`

## Requirements
- R1: When reset is held low across a rising clock edge, the data and direction registers become 0. With no peripheral enabled, every pin_oe bit and every pin_out bit is then 0.
- R2: A write with reg_wr=1 updates a register at the next rising edge. reg_addr=0 selects the data register and reg_addr=1 selects the direction register. With reg_wr=0 neither register changes.
- R3: With reg_addr=1, reg_rdata returns the direction register. With reg_addr=0, each bit of reg_rdata returns the stored data bit when its direction bit is 1 and pin_in when its direction bit is 0.
- R4: A pin that no enabled peripheral claims has pin_oe equal to its direction bit and pin_out equal to its data bit.
- R5: With spi_en=1 and spi_master=1, bits 4 and 3 drive spi_mosi_to_pad and spi_ss_to_pad with pin_oe=1. Bit 2 is an input, with pin_oe=0 and pin_out=0.
- R6: With spi_en=1 and spi_master=0, bits 4 and 3 are inputs, with pin_oe=0 and pin_out=0. Bit 2 drives spi_miso_to_pad with pin_oe=1.
- R7: With can_en=1, bit 1 drives can_tx_to_pad with pin_oe=1. Bit 0 is an input, with pin_oe=0 and pin_out=0.
- R8: With uart_en=1 and can_en=0, bit 1 drives uart_txd_to_pad with pin_oe=1. Bit 0 is an input, with pin_oe=0 and pin_out=0.
- R9: With both can_en and uart_en set, the CAN function owns bits 1 and 0 and the UART transmit value has no effect on any pin.
- R10: While a peripheral owns a pin, writes to the data and direction registers are still stored and the readback rule of R3 still applies. Those writes do not change pin_out or pin_oe on the owned pins.
- R11: spi_mosi_from_pad, spi_ss_from_pad and spi_miso_from_pad always equal pin_in bits 4, 3 and 2. can_rx_from_pad and uart_rxd_from_pad always equal pin_in bit 0, whichever function owns the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 selects data, 1 selects direction |
| reg_wdata | input | 5 | Write data |
| reg_rdata | output | 5 | Readback of the selected register |
| pin_in | input | 5 | Synchronized pin input states |
| pin_out | output | 5 | Per-pin output value |
| pin_oe | output | 5 | Per-pin output enable |
| spi_en | input | 1 | SPI claims bits 4 to 2 |
| spi_master | input | 1 | SPI master (1) or slave (0) mode |
| spi_mosi_to_pad | input | 1 | MOSI value from the SPI |
| spi_ss_to_pad | input | 1 | Slave-select value from the SPI |
| spi_miso_to_pad | input | 1 | MISO value from the SPI |
| spi_mosi_from_pad | output | 1 | MOSI pin state routed to the SPI |
| spi_ss_from_pad | output | 1 | Slave-select pin state routed to the SPI |
| spi_miso_from_pad | output | 1 | MISO pin state routed to the SPI |
| can_en | input | 1 | CAN claims bits 1 and 0 |
| can_tx_to_pad | input | 1 | CAN transmit value |
| can_rx_from_pad | output | 1 | Receive pin state routed to the CAN |
| uart_en | input | 1 | UART claims bits 1 and 0 when CAN is off |
| uart_txd_to_pad | input | 1 | UART transmit value |
| uart_rxd_from_pad | output | 1 | Receive pin state routed to the UART |

## Verification
A wrong value in the data or direction register shows up one edge after the write. It appears on reg_rdata and, for any pin that no peripheral owns, on pin_out or pin_oe in the same cycle. A wrong ownership decision is combinational, so it shows up at once as the wrong drive source or a reversed output enable on the claimed pins. The bench compares every output against an independent model after each change, including changes to the peripheral enables and to the SPI mode. A corrupted register hidden behind a peripheral still shows up at the first readback of that register.

// File: rtl/gpio_altfunc_pkg.sv
// Shared constants and types for the GPIO port with peripheral override.
// Assumes the fixed five-pin layout: SPI on bits 4..2, CAN/UART on bits 1..0.
package gpio_altfunc_pkg;

    localparam int PORT_W   = 5;
    localparam int PIN_MOSI = 4;
    localparam int PIN_SS   = 3;
    localparam int PIN_MISO = 2;
    localparam int PIN_TX   = 1;
    localparam int PIN_RX   = 0;

    typedef enum logic [1:0] {
        OWN_GPIO = 2'd0,
        OWN_SPI  = 2'd1,
        OWN_CAN  = 2'd2,
        OWN_UART = 2'd3
    } pin_owner_e;

    typedef struct packed {
        pin_owner_e owner;
        logic       drive;
        logic       value;
    } pin_ctl_t;

endpackage

// File: rtl/gpio_port_regs.sv
// Data and direction registers with the direction-dependent readback.
// Assumes a single-cycle write strobe and combinational readback.
module gpio_port_regs #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         addr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] rdata,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q
);

    // Store register writes; reset leaves every pin as an input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            if (addr) dir_q  <= wdata;
            else      data_q <= wdata;
        end
    end

    // Readback: direction register, or per-bit data/pin select.
    always_comb begin
        if (addr) rdata = dir_q;
        else      rdata = (dir_q & data_q) | (~dir_q & pin_in);
    end

    assert_data_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr) |=> (data_q == $past(wdata)));
    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr) |=> (dir_q == $past(wdata)));
    assert_no_write_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(data_q) && $stable(dir_q)));

endmodule

// File: rtl/gpio_owner_sel.sv
// Decides, per pin, which function owns it and what the peripheral drives.
// Assumes the fixed pin layout from the package; CAN outranks UART.
module gpio_owner_sel
    import gpio_altfunc_pkg::*;
#(
    parameter int W = 5
) (
    input  logic                spi_en,
    input  logic                spi_master,
    input  logic                spi_mosi_v,
    input  logic                spi_ss_v,
    input  logic                spi_miso_v,
    input  logic                can_en,
    input  logic                can_tx_v,
    input  logic                uart_en,
    input  logic                uart_tx_v,
    output pin_ctl_t [W-1:0]    ctl
);

    for (genvar g = 0; g < W; g++) begin : g_pin
        if (g == PIN_MOSI || g == PIN_SS) begin : g_spi_out_in_master
            // SPI master drives this pin; slave receives on it.
            always_comb begin
                ctl[g] = '{owner: OWN_GPIO, drive: 1'b0, value: 1'b0};
                if (spi_en) begin
                    ctl[g].owner = OWN_SPI;
                    ctl[g].drive = spi_master;
                    ctl[g].value = spi_master ? ((g == PIN_MOSI) ? spi_mosi_v : spi_ss_v) : 1'b0;
                end
            end
        end else if (g == PIN_MISO) begin : g_spi_out_in_slave
            // SPI slave drives MISO; master receives on it.
            always_comb begin
                ctl[g] = '{owner: OWN_GPIO, drive: 1'b0, value: 1'b0};
                if (spi_en) begin
                    ctl[g].owner = OWN_SPI;
                    ctl[g].drive = !spi_master;
                    ctl[g].value = spi_master ? 1'b0 : spi_miso_v;
                end
            end
        end else if (g == PIN_TX) begin : g_tx
            // Transmit pin: CAN first, then UART.
            always_comb begin
                ctl[g] = '{owner: OWN_GPIO, drive: 1'b0, value: 1'b0};
                if (can_en)       ctl[g] = '{owner: OWN_CAN,  drive: 1'b1, value: can_tx_v};
                else if (uart_en) ctl[g] = '{owner: OWN_UART, drive: 1'b1, value: uart_tx_v};
            end
        end else begin : g_rx
            // Receive pin: a claiming peripheral only listens.
            always_comb begin
                ctl[g] = '{owner: OWN_GPIO, drive: 1'b0, value: 1'b0};
                if (can_en)       ctl[g].owner = OWN_CAN;
                else if (uart_en) ctl[g].owner = OWN_UART;
            end
        end
    end

endmodule

// File: rtl/gpio_pad_drive.sv
// Combines GPIO register state with peripheral control into pad signals.
// Assumes ctl marks OWN_GPIO for pins that no peripheral claims.
module gpio_pad_drive
    import gpio_altfunc_pkg::*;
#(
    parameter int W = 5
) (
    input  pin_ctl_t [W-1:0] ctl,
    input  logic [W-1:0]     data_q,
    input  logic [W-1:0]     dir_q,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe
);

    for (genvar g = 0; g < W; g++) begin : g_pad
        // Pick GPIO register values or the owning peripheral's control.
        always_comb begin
            if (ctl[g].owner == OWN_GPIO) begin
                pin_out[g] = data_q[g];
                pin_oe[g]  = dir_q[g];
            end else begin
                pin_out[g] = ctl[g].value;
                pin_oe[g]  = ctl[g].drive;
            end
        end
    end

endmodule

// File: rtl/gpio_altfunc_port.sv
// Top of the five-pin GPIO port with SPI / CAN / UART pin override.
// Assumes pin_in is already synchronized to clk; reset is synchronous, active low.
module gpio_altfunc_port
    import gpio_altfunc_pkg::*;
#(
    parameter int PORT_WIDTH = PORT_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic                  reg_addr,
    input  logic [PORT_WIDTH-1:0] reg_wdata,
    output logic [PORT_WIDTH-1:0] reg_rdata,
    input  logic [PORT_WIDTH-1:0] pin_in,
    output logic [PORT_WIDTH-1:0] pin_out,
    output logic [PORT_WIDTH-1:0] pin_oe,
    input  logic                  spi_en,
    input  logic                  spi_master,
    input  logic                  spi_mosi_to_pad,
    input  logic                  spi_ss_to_pad,
    input  logic                  spi_miso_to_pad,
    output logic                  spi_mosi_from_pad,
    output logic                  spi_ss_from_pad,
    output logic                  spi_miso_from_pad,
    input  logic                  can_en,
    input  logic                  can_tx_to_pad,
    output logic                  can_rx_from_pad,
    input  logic                  uart_en,
    input  logic                  uart_txd_to_pad,
    output logic                  uart_rxd_from_pad
);

    logic [PORT_WIDTH-1:0]    data_q;
    logic [PORT_WIDTH-1:0]    dir_q;
    pin_ctl_t [PORT_WIDTH-1:0] ctl;

    gpio_port_regs #(.W(PORT_WIDTH)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .pin_in (pin_in),
        .rdata  (reg_rdata),
        .data_q (data_q),
        .dir_q  (dir_q)
    );

    gpio_owner_sel #(.W(PORT_WIDTH)) u_owner (
        .spi_en     (spi_en),
        .spi_master (spi_master),
        .spi_mosi_v (spi_mosi_to_pad),
        .spi_ss_v   (spi_ss_to_pad),
        .spi_miso_v (spi_miso_to_pad),
        .can_en     (can_en),
        .can_tx_v   (can_tx_to_pad),
        .uart_en    (uart_en),
        .uart_tx_v  (uart_txd_to_pad),
        .ctl        (ctl)
    );

    gpio_pad_drive #(.W(PORT_WIDTH)) u_pad (
        .ctl     (ctl),
        .data_q  (data_q),
        .dir_q   (dir_q),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    // Route receive-side pin states to every peripheral, regardless of owner.
    always_comb begin
        spi_mosi_from_pad = pin_in[PIN_MOSI];
        spi_ss_from_pad   = pin_in[PIN_SS];
        spi_miso_from_pad = pin_in[PIN_MISO];
        can_rx_from_pad   = pin_in[PIN_RX];
        uart_rxd_from_pad = pin_in[PIN_RX];
    end

    assert_gpio_free_pin_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!can_en && !uart_en) |-> (pin_oe[PIN_TX] == dir_q[PIN_TX] && pin_out[PIN_TX] == data_q[PIN_TX]));
    assert_spi_master_dirs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && spi_master) |-> (pin_oe[PIN_MOSI] && pin_oe[PIN_SS] && !pin_oe[PIN_MISO]
                                    && pin_out[PIN_MOSI] == spi_mosi_to_pad));
    assert_spi_slave_dirs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && !spi_master) |-> (!pin_oe[PIN_MOSI] && !pin_oe[PIN_SS] && pin_oe[PIN_MISO]
                                     && pin_out[PIN_MISO] == spi_miso_to_pad));
    assert_can_owns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        can_en |-> (pin_oe[PIN_TX] && pin_out[PIN_TX] == can_tx_to_pad && !pin_oe[PIN_RX]));
    assert_uart_owns_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (uart_en && !can_en) |-> (pin_oe[PIN_TX] && pin_out[PIN_TX] == uart_txd_to_pad && !pin_oe[PIN_RX]));
    assert_owned_pins_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_en && $stable(spi_en) && $stable(spi_master) && $stable(spi_mosi_to_pad)
         && $stable(spi_ss_to_pad) && $stable(spi_miso_to_pad))
        |-> ($stable(pin_oe[PIN_MOSI:PIN_MISO]) && $stable(pin_out[PIN_MOSI:PIN_MISO])));

endmodule

// File: tb/gpio_altfunc_port_test.sv
// Scoreboard bench: a driver pushes expected items, a monitor pops and compares.
module gpio_altfunc_port_test;

    localparam int W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0, reg_addr = 1'b0;
    logic [W-1:0] reg_wdata = '0, pin_in = '0;
    logic [W-1:0] reg_rdata, pin_out, pin_oe;
    logic spi_en = 0, spi_master = 0, spi_mosi_to_pad = 0, spi_ss_to_pad = 0, spi_miso_to_pad = 0;
    logic can_en = 0, can_tx_to_pad = 0, uart_en = 0, uart_txd_to_pad = 0;
    logic spi_mosi_from_pad, spi_ss_from_pad, spi_miso_from_pad, can_rx_from_pad, uart_rxd_from_pad;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] sh_data = '0, sh_dir = '0;

    typedef struct {
        string        tag;
        logic [W-1:0] out;
        logic [W-1:0] oe;
        logic [W-1:0] rd;
        logic [4:0]   rcv;
    } exp_t;
    exp_t q[$];

    always #10 clk = ~clk;

    gpio_altfunc_port uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .spi_en(spi_en), .spi_master(spi_master),
        .spi_mosi_to_pad(spi_mosi_to_pad), .spi_ss_to_pad(spi_ss_to_pad),
        .spi_miso_to_pad(spi_miso_to_pad), .spi_mosi_from_pad(spi_mosi_from_pad),
        .spi_ss_from_pad(spi_ss_from_pad), .spi_miso_from_pad(spi_miso_from_pad),
        .can_en(can_en), .can_tx_to_pad(can_tx_to_pad), .can_rx_from_pad(can_rx_from_pad),
        .uart_en(uart_en), .uart_txd_to_pad(uart_txd_to_pad), .uart_rxd_from_pad(uart_rxd_from_pad)
    );

    // Expected values from the requirements and the shadow register state.
    task automatic push_expect(input string tag);
        exp_t e;
        e.tag = tag;
        e.out = sh_data;
        e.oe  = sh_dir;
        if (spi_en) begin
            if (spi_master) begin
                e.out[4] = spi_mosi_to_pad; e.oe[4] = 1'b1;
                e.out[3] = spi_ss_to_pad;   e.oe[3] = 1'b1;
                e.out[2] = 1'b0;            e.oe[2] = 1'b0;
            end else begin
                e.out[4] = 1'b0; e.oe[4] = 1'b0;
                e.out[3] = 1'b0; e.oe[3] = 1'b0;
                e.out[2] = spi_miso_to_pad; e.oe[2] = 1'b1;
            end
        end
        if (can_en) begin
            e.out[1] = can_tx_to_pad; e.oe[1] = 1'b1;
            e.out[0] = 1'b0;          e.oe[0] = 1'b0;
        end else if (uart_en) begin
            e.out[1] = uart_txd_to_pad; e.oe[1] = 1'b1;
            e.out[0] = 1'b0;            e.oe[0] = 1'b0;
        end
        e.rd  = reg_addr ? sh_dir : ((sh_dir & sh_data) | (~sh_dir & pin_in));
        e.rcv = {pin_in[4], pin_in[3], pin_in[2], pin_in[0], pin_in[0]};
        q.push_back(e);
    endtask

    // Settle half a low phase after the negedge, then queue an expectation.
    task automatic expect_now(input string tag);
        #5;
        push_expect(tag);
        #1;
    endtask

    task automatic reg_write(input logic a, input logic [W-1:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a) sh_dir = v; else sh_data = v;
    endtask

    task automatic cmp(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Monitor: pop each expectation and compare it against the ports.
    initial begin
        forever begin
            exp_t e;
            wait (q.size() != 0);
            e = q.pop_front();
            cmp(e.tag, "pin_out", pin_out, e.out);
            cmp(e.tag, "pin_oe", pin_oe, e.oe);
            cmp(e.tag, "reg_rdata", reg_rdata, e.rd);
            cmp(e.tag, "routed_in", {spi_mosi_from_pad, spi_ss_from_pad, spi_miso_from_pad,
                                     can_rx_from_pad, uart_rxd_from_pad}, e.rcv);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        pin_in = 5'b10101;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state, all inputs, readback follows pins.
        reg_addr = 1'b0; expect_now("R1_reset_data");
        reg_addr = 1'b1; expect_now("R1_reset_dir");

        // R2 / R3 / R4: all outputs, then a mixed direction.
        reg_write(1'b1, 5'b11111);
        reg_write(1'b0, 5'b01010);
        reg_addr = 1'b0; expect_now("R2_R4_all_out");
        reg_write(1'b1, 5'b00101);
        reg_addr = 1'b0; expect_now("R3_mixed_dir");
        reg_addr = 1'b1; expect_now("R3_dir_readback");
        pin_in = 5'b01010;
        reg_addr = 1'b0; expect_now("R3_pin_change");
        // R2: no write strobe, registers hold.
        @(negedge clk); reg_wdata = 5'b11111; reg_addr = 1'b1;
        @(negedge clk); expect_now("R2_hold_without_strobe");

        // R5: SPI master.
        reg_write(1'b1, 5'b11111);
        @(negedge clk);
        spi_en = 1; spi_master = 1; spi_mosi_to_pad = 1; spi_ss_to_pad = 0; spi_miso_to_pad = 1;
        reg_addr = 1'b0; expect_now("R5_spi_master");
        spi_mosi_to_pad = 0; spi_ss_to_pad = 1;
        expect_now("R5_spi_master_vals");
        // R6: SPI slave.
        spi_master = 0;
        expect_now("R6_spi_slave");
        spi_miso_to_pad = 0;
        expect_now("R6_spi_slave_miso");
        // R10: write data and direction under SPI ownership.
        reg_write(1'b0, 5'b10100);
        reg_addr = 1'b0; expect_now("R10_write_under_spi");
        reg_write(1'b1, 5'b00011);
        reg_addr = 1'b0; expect_now("R10_dir_under_spi");
        reg_addr = 1'b1; expect_now("R10_dir_readback");
        @(negedge clk); spi_en = 0;
        expect_now("R4_spi_released");

        // R7: CAN.
        reg_write(1'b1, 5'b11111);
        @(negedge clk);
        can_en = 1; can_tx_to_pad = 0; uart_txd_to_pad = 1;
        reg_addr = 1'b0; expect_now("R7_can_tx0");
        can_tx_to_pad = 1; expect_now("R7_can_tx1");
        // R9: CAN beats UART.
        uart_en = 1; can_tx_to_pad = 0;
        expect_now("R9_can_over_uart");
        // R8: UART alone.
        can_en = 0;
        expect_now("R8_uart_tx1");
        uart_txd_to_pad = 0; expect_now("R8_uart_tx0");
        // R10: write while UART owns bits 1..0.
        reg_write(1'b0, 5'b00011);
        reg_addr = 1'b0; expect_now("R10_write_under_uart");
        uart_en = 0; expect_now("R4_uart_released");

        // R11: routed inputs across several pin patterns and owners.
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            pin_in = 5'(i * 7 + 3);
            spi_en = i[0]; spi_master = i[1]; can_en = i[2]; uart_en = !i[2];
            expect_now("R11_routed_inputs");
        end
        @(negedge clk);
        spi_en = 0; can_en = 0; uart_en = 0;
        // R1: reset mid-run clears registers again.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1; sh_data = '0; sh_dir = '0;
        reg_addr = 1'b1; expect_now("R1_reset_again");

        wait (q.size() == 0);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule